// File: doc/BRIEF.md
# Scan Sequencer with Multiboard Sync

This block paces the simultaneous sampling of all analog input channels. A clock divider sets the interval between samples. A scan starts on a host command or on a rising edge of an external trigger. Each sample strobe is followed one cycle later by a buffer write enable. Once a programmed number of samples has been taken, the block reports a full buffer: it flips the buffer select and raises an interrupt request at a programmable level.

Two run modes are available. A continuous scan wraps into the other buffer after each block and keeps running until the host stops it. A single-block scan halts after one block. Either mode can run on its own, as a master that repeats each of its strobes on a shared line, or as a slave that takes one sample per rising edge seen on that line. The reset values give a working continuous, independent scan at the slowest rate with the largest block, so the block can run without any programming.

Top module: `scan_sequencer`

## Requirements
- R1: After reset the block is idle with all outputs low and `buf_sel` at 0. The configuration resets to: continuous, independent, host start, divisor `DEF_DIV`, block size all ones, interrupt level 1.
- R2: With host start selected, a `host_start` high in cycle c makes `running` high from cycle c+1. The first strobe comes in cycle c+1+D, where D is the divisor, and further strobes follow every D+1 cycles.
- R3: With external start selected (`cfg_ext`=1), `ext_trig` passes through two synchronizing flops and only its rising edge starts a scan. A rise first driven in cycle c gives `running` from c+3. `host_start` has no effect in this mode, and a trigger held high starts only one scan.
- R4: In continuous mode (`cfg_single`=0), each strobe that completes a block of B samples toggles `buf_sel` and raises the interrupt in the next cycle. The count then reloads and scanning goes on.
- R5: In single-block mode (`cfg_single`=1), `running` clears in the cycle after the B-th strobe and no further strobes occur.
- R6: A `host_stop` in cycle s clears `running` from cycle s+1 with no later strobe. A strobe issued in cycle s is still completed and written.
- R7: `wr_en` is high in exactly the cycles that follow a `sample_strobe`.
- R8: With `cfg_sync`=01 (master), `sync_out` equals `sample_strobe`. With 00 (independent), 10 (slave) or 11, `sync_out` stays low.
- R9: With `cfg_sync`=10 (slave), a running block strobes only on rising edges of `sync_in`, two cycles after the rise is first driven, and the divider is not used. Edges that arrive while idle are ignored.
- R10: While an interrupt is pending, `irq_vec` has exactly bit L-1 set, where L is the level. `irq_ack` clears the pending interrupt, but a new buffer-full in the same cycle wins over the acknowledge. A level write of 0 keeps the previous level.
- R11: Configuration writes and start requests made while `running` is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_single | input | 1 | 1 = single block, 0 = continuous |
| cfg_sync | input | 2 | 00 independent, 01 master, 10 slave |
| cfg_ext | input | 1 | 1 = start on external trigger edge |
| cfg_div | input | DIV_W | Sample interval minus one, in clocks |
| cfg_blk | input | CNT_W | Samples per buffer block |
| cfg_lvl | input | 3 | Interrupt level 1..7 |
| host_start | input | 1 | Host start command |
| host_stop | input | 1 | Host stop command |
| ext_trig | input | 1 | Asynchronous external trigger |
| sync_in | input | 1 | Shared multiboard sync line (asynchronous) |
| irq_ack | input | 1 | Clears the pending interrupt |
| sample_strobe | output | 1 | Sample-and-hold strobe for all channels |
| wr_en | output | 1 | Buffer write enable for the last sample |
| sync_out | output | 1 | Master drive onto the shared sync line |
| buf_sel | output | 1 | Buffer currently being filled |
| running | output | 1 | Sequence active |
| irq_vec | output | 7 | One-hot interrupt request, bit L-1 for level L |

## Verification
The bench builds the block with DIV_W=8, CNT_W=4 and DEF_DIV=7. A default block is therefore 15 samples at one sample every 8 clocks. A default run can then cross a full block and toggle the buffer in about a hundred cycles. The narrow fields keep short divisors and block sizes of 2 to 5 within reach, so every mode can be shown reaching block end, single-block halt, a stop that lands on a strobe, and slave pacing inside a few thousand cycles.

// File: rtl/scan_sequencer.sv
module scan_sequencer #(
  parameter int DIV_W   = 12,
  parameter int CNT_W   = 17,
  parameter int DEF_DIV = 127
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_single,
  input  logic [1:0]       cfg_sync,
  input  logic             cfg_ext,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [CNT_W-1:0] cfg_blk,
  input  logic [2:0]       cfg_lvl,
  input  logic             host_start,
  input  logic             host_stop,
  input  logic             ext_trig,
  input  logic             sync_in,
  input  logic             irq_ack,
  output logic             sample_strobe,
  output logic             wr_en,
  output logic             sync_out,
  output logic             buf_sel,
  output logic             running,
  output logic [6:0]       irq_vec
);
  localparam logic [CNT_W-1:0] ONE_SAMPLE = CNT_W'(1);

  logic             single_r, ext_r, run_r, wr_r, buf_r, pend_r;
  logic [1:0]       sync_r;
  logic [2:0]       lvl_r, ext_s, syn_s;
  logic [DIV_W-1:0] div_r, div_cnt;
  logic [CNT_W-1:0] blk_r, remain;

  wire ext_rise  = ext_s[1] & ~ext_s[2];
  wire syn_rise  = syn_s[1] & ~syn_s[2];
  wire is_master = (sync_r == 2'b01);
  wire is_slave  = (sync_r == 2'b10);
  wire start     = !run_r && (ext_r ? ext_rise : host_start);
  wire tick      = run_r && (is_slave ? syn_rise : (div_cnt == div_r));
  wire blk_end   = tick && (remain == ONE_SAMPLE);

  assign sample_strobe = tick;
  assign sync_out      = tick && is_master;
  assign wr_en         = wr_r;
  assign buf_sel       = buf_r;
  assign running       = run_r;
  assign irq_vec       = pend_r ? (7'd1 << (lvl_r - 3'd1)) : 7'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_s <= '0;
      syn_s <= '0;
    end else begin
      ext_s <= {ext_s[1:0], ext_trig};
      syn_s <= {syn_s[1:0], sync_in};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      single_r <= 1'b0;
      sync_r   <= 2'b00;
      ext_r    <= 1'b0;
      div_r    <= DIV_W'(DEF_DIV);
      blk_r    <= '1;
      lvl_r    <= 3'd1;
      run_r    <= 1'b0;
      wr_r     <= 1'b0;
      buf_r    <= 1'b0;
      pend_r   <= 1'b0;
      div_cnt  <= '0;
      remain   <= '0;
    end else begin
      wr_r <= tick;
      if (cfg_we && !run_r) begin
        single_r <= cfg_single;
        sync_r   <= cfg_sync;
        ext_r    <= cfg_ext;
        div_r    <= cfg_div;
        blk_r    <= cfg_blk;
        if (cfg_lvl != 3'd0) lvl_r <= cfg_lvl;
      end
      if (start) begin
        run_r   <= 1'b1;
        div_cnt <= '0;
        remain  <= blk_r;
      end else if (run_r) begin
        div_cnt <= tick ? '0 : div_cnt + 1'b1;
        if (tick) begin
          if (blk_end) begin
            buf_r  <= ~buf_r;
            remain <= blk_r;
            if (single_r) run_r <= 1'b0;
          end else begin
            remain <= remain - 1'b1;
          end
        end
        if (host_stop) run_r <= 1'b0;
      end
      if (blk_end) pend_r <= 1'b1;
      else if (irq_ack) pend_r <= 1'b0;
    end
  end

  assert_write_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sample_strobe |=> wr_en);
  assert_single_halts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (single_r && blk_end) |=> !running);
  assert_stop_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_stop && running) |=> !running);
  assert_cfg_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running)) |-> ($stable(div_r) && $stable(blk_r) && $stable(sync_r)));
  assert_irq_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_vec != 7'd0 && !irq_ack) |=> (irq_vec != 7'd0));
  assert_irq_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_vec));
endmodule

// File: tb/scan_sequencer_test.sv
module scan_sequencer_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_single = 0, cfg_ext = 0;
  logic [1:0] cfg_sync = 0;
  logic [7:0] cfg_div = 0;
  logic [3:0] cfg_blk = 0;
  logic [2:0] cfg_lvl = 0;
  logic host_start = 0, host_stop = 0, ext_trig = 0, sync_in = 0, irq_ack = 0;
  logic sample_strobe, wr_en, sync_out, buf_sel, running;
  logic [6:0] irq_vec;

  scan_sequencer #(.DIV_W(8), .CNT_W(4), .DEF_DIV(7)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_single(cfg_single),
    .cfg_sync(cfg_sync), .cfg_ext(cfg_ext), .cfg_div(cfg_div), .cfg_blk(cfg_blk),
    .cfg_lvl(cfg_lvl), .host_start(host_start), .host_stop(host_stop),
    .ext_trig(ext_trig), .sync_in(sync_in), .irq_ack(irq_ack),
    .sample_strobe(sample_strobe), .wr_en(wr_en), .sync_out(sync_out),
    .buf_sel(buf_sel), .running(running), .irq_vec(irq_vec));

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0, bad = 0;
  int exp_q[$];
  bit exp_buf_q[$];
  bit master_mode = 0, buf_b = 0, prev_s = 0;
  int nsamp = 0, blk_b = 15, div_b = 7;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic void push(input int c);
    exp_q.push_back(c);
    exp_buf_q.push_back(buf_b);
    nsamp++;
    if (nsamp == blk_b) begin nsamp = 0; buf_b = ~buf_b; end
  endfunction

  // monitor: scoreboard of strobe cycles, write enable and sync drive
  always @(negedge clk) if (rst_n) begin
    if (wr_en || prev_s) chk(wr_en == prev_s, "R7 wr_en", wr_en, prev_s);
    if (sample_strobe || sync_out)
      chk(sync_out == (sample_strobe && master_mode), "R8 sync_out", sync_out, sample_strobe && master_mode);
    if (sample_strobe) begin
      if (exp_q.size() == 0) chk(0, "R2/R5/R6/R9 unexpected strobe", cyc, -1);
      else begin
        int e;
        bit eb;
        e = exp_q.pop_front();
        eb = exp_buf_q.pop_front();
        chk(cyc == e, "R2/R4/R9 strobe cycle", cyc, e);
        chk(buf_sel == eb, "R4 buf_sel", buf_sel, eb);
      end
    end
    prev_s = sample_strobe;
  end

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic cfg(input bit s, input bit [1:0] sy, input bit e, input int d, input int b, input int l);
    @(negedge clk);
    cfg_single = s; cfg_sync = sy; cfg_ext = e;
    cfg_div = 8'(d); cfg_blk = 4'(b); cfg_lvl = 3'(l); cfg_we = 1;
    @(negedge clk) cfg_we = 0;
  endtask

  task automatic host_go(input int n, output int c);
    @(negedge clk);
    c = cyc;
    nsamp = 0;
    for (int i = 0; i < n; i++) push(c + 1 + div_b + i * (div_b + 1));
    host_start = 1;
    @(negedge clk) host_start = 0;
  endtask

  task automatic stop_now();
    host_stop = 1;
    @(negedge clk) host_stop = 0;
  endtask

  task automatic ack();
    @(negedge clk) irq_ack = 1;
    @(negedge clk) irq_ack = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int c, p;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(running == 0, "R1 running", running, 0);
    chk(irq_vec == 0, "R1 irq_vec", irq_vec, 0);
    chk(buf_sel == 0, "R1 buf_sel", buf_sel, 0);
    chk(sample_strobe == 0 && wr_en == 0, "R1 strobe/wr", sample_strobe, 0);

    // R1 defaults + R2 + R4: continuous, div 7, block 15, level 1
    host_go(16, c);
    chk(running == 1, "R2 running after start", running, 1);
    wait_until(c + 120);
    chk(irq_vec == 0, "R4 no irq before block end", irq_vec, 0);
    wait_until(c + 129);
    chk(irq_vec == 7'b0000001, "R4 R10 irq at default level", irq_vec, 1);
    chk(running == 1, "R4 continuous keeps running", running, 1);
    stop_now();
    chk(running == 0, "R6 stop", running, 0);
    repeat (20) @(negedge clk);
    ack();
    chk(irq_vec == 0, "R10 ack clears", irq_vec, 0);

    // R5 R11 R10: single block, div 2, block 4, level 3
    cfg(1, 2'b00, 0, 2, 4, 3);
    div_b = 2; blk_b = 4;
    host_go(4, c);
    wait_until(c + 4);
    cfg(0, 2'b01, 1, 5, 9, 5);
    wait_until(c + 14);
    chk(running == 0, "R5 single halts", running, 0);
    chk(irq_vec == 7'b0000100, "R10 level 3", irq_vec, 4);
    repeat (20) @(negedge clk);
    ack();
    host_go(4, c);
    wait_until(c + 5);
    host_start = 1;
    @(negedge clk) host_start = 0;
    wait_until(c + 14);
    chk(running == 0, "R11 config and restart ignored", running, 0);
    chk(irq_vec == 7'b0000100, "R11 level unchanged", irq_vec, 4);
    ack();
    cfg(1, 2'b00, 0, 1, 2, 0);
    div_b = 1; blk_b = 2;
    host_go(2, c);
    wait_until(c + 7);
    chk(irq_vec == 7'b0000100, "R10 level 0 write keeps level", irq_vec, 4);
    ack();

    // R3 external trigger
    cfg(1, 2'b00, 1, 3, 3, 1);
    div_b = 3; blk_b = 3;
    @(negedge clk) host_start = 1;
    @(negedge clk) host_start = 0;
    repeat (3) @(negedge clk);
    chk(running == 0, "R3 host_start ignored", running, 0);
    c = cyc;
    nsamp = 0;
    for (int i = 0; i < 3; i++) push(c + 6 + i * 4);
    ext_trig = 1;
    @(negedge clk);
    @(negedge clk);
    chk(running == 0, "R3 sync latency", running, 0);
    @(negedge clk);
    chk(running == 1, "R3 started at c+3", running, 1);
    wait_until(c + 40);
    chk(running == 0, "R3 held trigger starts once", running, 0);
    ext_trig = 0;
    ack();

    // R8 master + R6 stop on a strobe cycle
    cfg(0, 2'b01, 0, 4, 5, 1);
    master_mode = 1; div_b = 4; blk_b = 5;
    host_go(3, c);
    wait_until(c + 15);
    stop_now();
    chk(running == 0, "R6 stop in strobe cycle", running, 0);
    repeat (20) @(negedge clk);

    // R9 slave
    cfg(0, 2'b10, 0, 1, 2, 1);
    master_mode = 0; blk_b = 2; nsamp = 0;
    @(negedge clk) sync_in = 1;
    @(negedge clk) sync_in = 0;
    repeat (5) @(negedge clk);
    @(negedge clk) host_start = 1;
    @(negedge clk) host_start = 0;
    repeat (10) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      p = cyc;
      push(p + 2);
      sync_in = 1;
      @(negedge clk) sync_in = 0;
      repeat (6) @(negedge clk);
    end
    chk(irq_vec == 7'b0000001, "R9 slave block end", irq_vec, 1);
    stop_now();
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R2/R9 all strobes seen", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule